// File: doc/BRIEF.md
# SPI Slave Register and RAM Access Controller

This block is the serial front end of a peripheral. An external SPI master (mode 0: SCLK idles low, SI captured on the rising edge, everything MSB first) addresses a 64-entry file of 16-bit registers, a 512-byte RAM organised as four 128-byte banks, or a transmit FIFO. SCLK, CSn and SI are asynchronous to the block. They pass through two-stage synchronisers into a faster system clock, and every edge of SCLK is found by comparing samples. SO is updated a few system clocks after each falling SCLK edge.

The first byte of every transaction is a command. While the master shifts it in, the block shifts out the 8-bit status word taken from `status_in`. The command picks one of these:
- a 16-bit register read or write;
- a no-operation;
- a stream of byte pushes into the transmit FIFO, during which the status word is returned again for every byte;
- a RAM access, whose second byte carries the bank and a read-only flag. Data bytes then run with an address that advances by one per byte.

On the core side the block only issues single-cycle request pulses with address and data. The register file and the RAM return read data on combinational paths.

Top module: `spi_access_ctrl`

## Requirements
- R1: While CSn is low, `so_oe` is 1 and SO carries the current `status_in`, MSB first, during the command byte. Within a few system clocks after CSn goes high, `so_oe` returns to 0.
- R2: A command byte with bit 7 = 0 and bit 6 = 0 is a register write to the address in bits 5:0. After the 16th following data bit, a single `reg_we` pulse presents that address and the 16 received bits, first bit as bit 15.
- R3: A command byte with bit 7 = 0 and bit 6 = 1 is a register read. It raises `reg_re` with the address. The 16 bits of `reg_rdata` are then returned on SO over the next two bytes, bit 15 first.
- R4: A command byte with bit 7 = 1 starts a RAM access with address low bits 6:0. In the second byte, bits 7:6 are the bank and bit 5 is the mode (1 = read only, 0 = read and write). Bits 4:0 of that byte are ignored. The address is {bank, low bits}, and SO carries zeros during the second byte.
- R5: RAM read data appears on SO from the third byte onward. After every data byte the RAM address advances by one and `ram_re` pulses for the new address.
- R6: In read-and-write mode, each data byte received is written with `ram_we` to the address whose contents were just shifted out. In read-only mode, `ram_we` never pulses.
- R7: A register write command to address 0x3E is a transmit FIFO stream. Each following complete byte gives one `fifo_push` pulse with that byte, and SO returns the status word during every byte.
- R8: A command to address 0x00 (either direction) is a no-operation. Only the status word is returned. Later bytes produce no pulse and SO carries zeros.
- R9: CSn rising at any point aborts the transaction. A partly received byte or register word is never committed, and the next transaction decodes a fresh command.
- R10: A register transaction performs one access only. Bytes after its 16 data bits cause no further `reg_we` or `reg_re`.
- R11: `reg_we`, `ram_we` and `fifo_push` last one clock each, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from master |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for SO |
| status_in | input | 8 | Status word returned with commands and FIFO bytes |
| reg_addr | output | 6 | Register address |
| reg_wdata | output | 16 | Register write data |
| reg_we | output | 1 | Register write pulse |
| reg_re | output | 1 | Register read pulse |
| reg_rdata | input | 16 | Register read data |
| ram_addr | output | 9 | RAM address {bank, low} |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write pulse |
| ram_re | output | 1 | RAM read pulse |
| ram_rdata | input | 8 | RAM read data |
| fifo_wdata | output | 8 | FIFO push data |
| fifo_push | output | 1 | FIFO push pulse |

## Verification
The in-line properties cover the cycle-level rules on every clock:
- the write strobes last one cycle and never coincide;
- a RAM write is followed at once by a read request at the next address;
- a RAM write never occurs in read-only mode;
- the SO enable drops once chip select is released.

The decode itself can only be shown by the directed scenarios. Those scenarios cover which command maps to which access, the bit order of returned register and RAM data, the zeros returned in the bank byte and after a no-operation, the read-before-overwrite order of a read-and-write stream, and the absence of any commit after a mid-byte abort.

// File: rtl/spi_access_ctrl.sv
module spi_access_ctrl #(
  parameter logic [5:0] FIFO_ADDR = 6'h3E,
  parameter logic [5:0] NOP_ADDR  = 6'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        si,
  output logic        so,
  output logic        so_oe,
  input  logic [7:0]  status_in,
  output logic [5:0]  reg_addr,
  output logic [15:0] reg_wdata,
  output logic        reg_we,
  output logic        reg_re,
  input  logic [15:0] reg_rdata,
  output logic [8:0]  ram_addr,
  output logic [7:0]  ram_wdata,
  output logic        ram_we,
  output logic        ram_re,
  input  logic [7:0]  ram_rdata,
  output logic [7:0]  fifo_wdata,
  output logic        fifo_push
);

  typedef enum logic [2:0] {
    S_CMD, S_REG_HI, S_REG_LO, S_RAM_BANK, S_RAM_DATA, S_FIFO, S_DONE
  } state_t;

  logic [2:0] sclk_q, cs_q;
  logic [1:0] si_q;
  state_t     state;
  logic [2:0] cnt;
  logic [6:0] rx;
  logic [7:0] tx, wr_hi, rd_lo;
  logic [6:0] ram_lo;
  logic       is_read, ro_q, inc_pend;

  wire sclk_rise = sclk_q[1] & ~sclk_q[2];
  wire sclk_fall = ~sclk_q[1] & sclk_q[2];
  wire cs_act    = ~cs_q[1];
  wire cs_start  = cs_act & cs_q[2];
  wire [7:0] byte_in = {rx, si_q[1]};

  assign so = tx[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      si_q   <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[1:0], cs_n};
      si_q   <= {si_q[0], si};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_CMD;  cnt <= '0;  rx <= '0;  tx <= '0;
      wr_hi <= '0;  rd_lo <= '0;  ram_lo <= '0;
      is_read <= 1'b0;  ro_q <= 1'b0;  inc_pend <= 1'b0;
      so_oe <= 1'b0;
      reg_addr <= '0;  reg_wdata <= '0;  reg_we <= 1'b0;  reg_re <= 1'b0;
      ram_addr <= '0;  ram_wdata <= '0;  ram_we <= 1'b0;  ram_re <= 1'b0;
      fifo_wdata <= '0;  fifo_push <= 1'b0;
    end else begin
      reg_we <= 1'b0;  reg_re <= 1'b0;
      ram_we <= 1'b0;  ram_re <= 1'b0;
      fifo_push <= 1'b0;
      so_oe <= cs_act;

      if (inc_pend) begin
        ram_addr <= ram_addr + 9'd1;
        ram_re   <= 1'b1;
        inc_pend <= 1'b0;
      end

      if (!cs_act) begin
        state <= S_CMD;
        cnt   <= '0;
        tx    <= '0;
      end else begin
        if (cs_start) begin
          tx <= status_in;
        end else if (sclk_fall) begin
          if (cnt == 3'd0) begin
            case (state)
              S_REG_HI: begin
                tx    <= is_read ? reg_rdata[15:8] : 8'h00;
                rd_lo <= reg_rdata[7:0];
              end
              S_REG_LO:   tx <= is_read ? rd_lo : 8'h00;
              S_RAM_DATA: tx <= ram_rdata;
              S_FIFO:     tx <= status_in;
              default:    tx <= 8'h00;
            endcase
          end else begin
            tx <= {tx[6:0], 1'b0};
          end
        end

        if (sclk_rise) begin
          cnt <= cnt + 3'd1;
          rx  <= byte_in[6:0];
          if (cnt == 3'd7) begin
            case (state)
              S_CMD: begin
                if (byte_in[7]) begin
                  ram_lo <= byte_in[6:0];
                  state  <= S_RAM_BANK;
                end else begin
                  reg_addr <= byte_in[5:0];
                  is_read  <= byte_in[6];
                  if (byte_in[5:0] == NOP_ADDR) begin
                    state <= S_DONE;
                  end else if (!byte_in[6] && byte_in[5:0] == FIFO_ADDR) begin
                    state <= S_FIFO;
                  end else begin
                    state  <= S_REG_HI;
                    reg_re <= byte_in[6];
                  end
                end
              end
              S_REG_HI: begin
                wr_hi <= byte_in;
                state <= S_REG_LO;
              end
              S_REG_LO: begin
                if (!is_read) begin
                  reg_we    <= 1'b1;
                  reg_wdata <= {wr_hi, byte_in};
                end
                state <= S_DONE;
              end
              S_RAM_BANK: begin
                ram_addr <= {byte_in[7:6], ram_lo};
                ro_q     <= byte_in[5];
                ram_re   <= 1'b1;
                state    <= S_RAM_DATA;
              end
              S_RAM_DATA: begin
                if (!ro_q) begin
                  ram_we    <= 1'b1;
                  ram_wdata <= byte_in;
                end
                inc_pend <= 1'b1;
              end
              S_FIFO: begin
                fifo_push  <= 1'b1;
                fifo_wdata <= byte_in;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  // R11
  strobes_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_we, ram_we, fifo_push}));

  // R11
  reg_we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R7
  fifo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |=> !fifo_push);

  // R5
  ram_next_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> (ram_re && ram_addr == $past(ram_addr) + 9'd1));

  // R6
  ram_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !ro_q);

  // R1
  so_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !so_oe);

endmodule

// File: tb/spi_access_ctrl_tb.sv
module spi_access_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam logic [7:0] STAT = 8'hA5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe;
  logic [7:0]  status_in = STAT;
  logic [5:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        reg_we, reg_re, ram_we, ram_re, fifo_push;
  logic [8:0]  ram_addr;
  logic [7:0]  ram_wdata, ram_rdata, fifo_wdata;

  logic [15:0] regs [0:63];
  logic [7:0]  mem  [0:511];
  int n_chk = 0, n_fail = 0;
  int n_reg_we = 0, n_reg_re = 0, n_ram_we = 0, n_fifo = 0;
  logic [7:0]  fifo_log [0:7];
  logic [5:0]  last_re_addr;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_access_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si),
    .so(so), .so_oe(so_oe), .status_in(status_in),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .ram_re(ram_re), .ram_rdata(ram_rdata),
    .fifo_wdata(fifo_wdata), .fifo_push(fifo_push)
  );

  assign reg_rdata = regs[reg_addr];
  assign ram_rdata = mem[ram_addr];

  always @(posedge clk) begin
    if (reg_we) begin regs[reg_addr] <= reg_wdata; n_reg_we <= n_reg_we + 1; end
    if (reg_re) begin last_re_addr <= reg_addr; n_reg_re <= n_reg_re + 1; end
    if (ram_we) begin mem[ram_addr] <= ram_wdata; n_ram_we <= n_ram_we + 1; end
    if (fifo_push) begin fifo_log[n_fifo[2:0]] <= fifo_wdata; n_fifo <= n_fifo + 1; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input int nb, input logic [7:0] mo, output logic [7:0] mi);
    mi = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      si = mo[i];
      wait_clk(HALF);
      mi[i] = so;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] mo, output logic [7:0] mi);
    spi_bits(8, mo, mi);
  endtask

  task automatic cs_begin;
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_end;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(3 * HALF);
  endtask

  task automatic t_nop;
    logic [7:0] mi;
    int we0 = n_reg_we, re0 = n_reg_re, rw0 = n_ram_we, f0 = n_fifo;
    cs_begin();
    chk(so_oe == 1'b1, "R1 so_oe during transfer", {31'd0, so_oe}, 1);
    spi_byte(8'h00, mi);
    chk(mi == STAT, "R1 status on command byte", mi, STAT);
    spi_byte(8'hFF, mi);
    chk(mi == 8'h00, "R8 zeros after no-op", mi, 0);
    cs_end();
    chk((n_reg_we - we0) + (n_reg_re - re0) + (n_ram_we - rw0) + (n_fifo - f0) == 0,
        "R8 no-op produced no pulse", n_reg_we + n_reg_re, we0 + re0);
    chk(so_oe == 1'b0, "R1 so_oe off after CSn high", {31'd0, so_oe}, 0);
  endtask

  task automatic t_reg_write;
    logic [7:0] mi;
    int we0 = n_reg_we;
    cs_begin();
    spi_byte(8'h05, mi);
    chk(mi == STAT, "R1 status on write command", mi, STAT);
    spi_byte(8'h12, mi);
    spi_byte(8'h34, mi);
    wait_clk(6);
    chk(n_reg_we == we0 + 1, "R2 one write pulse", n_reg_we - we0, 1);
    chk(regs[5] == 16'h1234, "R2 register written", regs[5], 16'h1234);
    spi_byte(8'h56, mi);
    spi_byte(8'h78, mi);
    cs_end();
    chk(n_reg_we == we0 + 1, "R10 extra bytes ignored", n_reg_we - we0, 1);
    chk(regs[5] == 16'h1234, "R10 register unchanged", regs[5], 16'h1234);
  endtask

  task automatic t_reg_read;
    logic [7:0] hi, lo, mi;
    int re0 = n_reg_re;
    cs_begin();
    spi_byte(8'h47, mi);
    spi_byte(8'h00, hi);
    spi_byte(8'h00, lo);
    cs_end();
    chk(n_reg_re == re0 + 1 && last_re_addr == 6'd7, "R3 read request",
        {26'd0, last_re_addr}, 7);
    chk({hi, lo} == regs[7], "R3 read data on SO", {hi, lo}, regs[7]);
  endtask

  task automatic t_ram_rw;
    logic [7:0] mi, r0, r1, e0, e1;
    int rw0 = n_ram_we;
    e0 = mem[9'h110];
    e1 = mem[9'h111];
    cs_begin();
    spi_byte(8'h90, mi);
    spi_byte(8'h9F, mi);
    chk(mi == 8'h00, "R4 zeros during bank byte", mi, 0);
    spi_byte(8'h11, r0);
    spi_byte(8'h22, r1);
    cs_end();
    chk(r0 == e0, "R5 first RAM byte at {bank,low}", r0, e0);
    chk(r1 == e1, "R5 second RAM byte at next address", r1, e1);
    chk(n_ram_we == rw0 + 2, "R6 one write per data byte", n_ram_we - rw0, 2);
    chk(mem[9'h110] == 8'h11 && mem[9'h111] == 8'h22, "R6 bytes replaced",
        {mem[9'h110], mem[9'h111]}, 16'h1122);
  endtask

  task automatic t_ram_ro;
    logic [7:0] mi, r0, r1, e0, e1;
    int rw0 = n_ram_we;
    e0 = mem[9'h0FF];
    e1 = mem[9'h100];
    cs_begin();
    spi_byte(8'hFF, mi);
    spi_byte(8'h60, mi);
    spi_byte(8'hAA, r0);
    spi_byte(8'hBB, r1);
    cs_end();
    chk(r0 == e0, "R4 bank 01 address 7F", r0, e0);
    chk(r1 == e1, "R5 increment crosses bank", r1, e1);
    chk(n_ram_we == rw0, "R6 read-only writes nothing", n_ram_we - rw0, 0);
    chk(mem[9'h0FF] == e0, "R6 read-only memory intact", mem[9'h0FF], e0);
  endtask

  task automatic t_fifo;
    logic [7:0] m0, m1, m2;
    int f0 = n_fifo;
    cs_begin();
    spi_byte(8'h3E, m0);
    spi_byte(8'hC3, m1);
    spi_byte(8'h3C, m2);
    cs_end();
    chk(n_fifo == f0 + 2, "R7 two pushes", n_fifo - f0, 2);
    chk(fifo_log[f0[2:0]] == 8'hC3 && fifo_log[f0[2:0] + 3'd1] == 8'h3C, "R7 push data",
        {fifo_log[f0[2:0]], fifo_log[f0[2:0] + 3'd1]}, 16'hC33C);
    chk(m1 == STAT && m2 == STAT, "R7 status during data bytes", {m1, m2}, {STAT, STAT});
  endtask

  task automatic t_abort;
    logic [7:0] mi;
    int we0 = n_reg_we, rw0 = n_ram_we;
    logic [7:0] keep;
    cs_begin();
    spi_byte(8'h06, mi);
    spi_byte(8'hDE, mi);
    spi_bits(4, 8'hAD, mi);
    cs_end();
    chk(n_reg_we == we0, "R9 partial register word dropped", n_reg_we - we0, 0);
    keep = mem[9'h020];
    cs_begin();
    spi_byte(8'hA0, mi);
    spi_byte(8'h00, mi);
    spi_bits(5, 8'h77, mi);
    cs_end();
    chk(n_ram_we == rw0 && mem[9'h020] == keep, "R9 partial RAM byte dropped",
        mem[9'h020], keep);
    cs_begin();
    spi_byte(8'h06, mi);
    chk(mi == STAT, "R9 fresh command after abort", mi, STAT);
    spi_byte(8'hBE, mi);
    spi_byte(8'hEF, mi);
    cs_end();
    chk(regs[6] == 16'hBEEF, "R9 fresh decode writes", regs[6], 16'hBEEF);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) regs[i] = 16'hC000 + 16'(i * 37);
    for (int i = 0; i < 512; i++) mem[i] = 8'(i) ^ 8'h5A;
    wait_clk(5);
    chk(so_oe == 1'b0 && reg_we == 1'b0 && ram_we == 1'b0 && fifo_push == 1'b0,
        "R1 reset state", {28'd0, so_oe, reg_we, ram_we, fifo_push}, 0);
    rst_n = 1'b1;
    wait_clk(5);
    t_nop();
    t_reg_write();
    t_reg_read();
    t_ram_rw();
    t_ram_ro();
    t_fifo();
    t_abort();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule